// File: doc/BRIEF.md
# Word-Resolved Wide Adder with Redundant Output

This block adds two very wide unsigned operands, hundreds to thousands of bits, by cutting them into equal words and giving every word its own short carry chain. The words are added side by side with no carry coming in, which yields a redundant carry-save result: a vector of word sums plus a sparse vector of word carries. A parallel prefix network of the Kogge-Stone kind then works only at word level. It uses one generate bit and one propagate bit per word to find the true carry that enters every word. A final increment in each word folds that carry in, which gives the fully resolved sum and the carry-out.

Both forms leave the block. A consumer that can accept redundant numbers, for example a further accumulation stage, can take the carry-save pair. A consumer that needs a plain binary value takes the resolved sum. All outputs are captured in registers, so a result appears one clock after its operands are presented. The word count and the word width are parameters.

Top module: `hcsa_adder_top`

## Requirements
- R1: Word i of the redundant sum output holds bits i*W to i*W+W-1 of (word i of A + word i of B), taken modulo 2^W, with no carry entering from word i-1.
- R2: The redundant carry vector is N*W+1 bits wide. Bit (i+1)*W holds the carry-out of the independent addition of word i. Every other bit, including bit 0, is zero.
- R3: The redundant sum plus the redundant carry vector equals A + B exactly, as an (N*W+1)-bit value.
- R4: The resolved sum output equals the low N*W bits of A + B.
- R5: The carry-out output equals bit N*W of A + B.
- R6: A carry produced in a low word passes through any run of words whose independent sums are all ones, and stops at the first word that is not all ones. When that run reaches the top word, the carry lands on the carry-out.
- R7: Every output is registered. A result shows on the outputs after the first rising clock edge at which its operands were sampled, and it stays there until the next rising edge.
- R8: While the synchronous active-high reset is sampled high at a rising edge, every output becomes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every output register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | N*W | First operand |
| op_b | input | N*W | Second operand |
| cs_sum | output | N*W | Redundant form: independent per-word sums |
| cs_carry | output | N*W+1 | Redundant form: word carries placed at word boundaries |
| res_sum | output | N*W | Resolved sum, low N*W bits of A + B |
| res_cout | output | 1 | Carry-out of the resolved sum |

## Verification
The assertions assume that both operands carry known 0/1 values on every bit at every rising edge outside reset. The word-sum and resolved-sum relations are only meaningful for defined inputs. The stimulus meets this by driving every operand bit to a definite value on the falling edge, starting before the first edge at which reset is released. It also holds the operands between updates, so no edge ever samples an undriven bus.

// File: rtl/hcsa_pkg.sv
package hcsa_pkg;

  // Word-level carry status used by the prefix network.
  typedef struct packed {
    logic gen;
    logic prop;
  } word_gp_t;

  // Merge a more significant span (hi) with the span just below it (lo).
  function automatic word_gp_t gp_merge(word_gp_t hi, word_gp_t lo);
    word_gp_t m;
    m.gen  = hi.gen | (hi.prop & lo.gen);
    m.prop = hi.prop & lo.prop;
    return m;
  endfunction

endpackage

// File: rtl/hcsa_word_add.sv
module hcsa_word_add #(
  parameter int W = 17
) (
  input  logic [W-1:0]            a_w,
  input  logic [W-1:0]            b_w,
  output logic [W-1:0]            s_w,
  output logic                    c_w,
  output hcsa_pkg::word_gp_t      gp_w
);
  logic [W:0] local_sum;

  // Local ripple addition with no carry in.
  always_comb begin
    local_sum = {1'b0, a_w} + {1'b0, b_w};
    s_w       = local_sum[W-1:0];
    c_w       = local_sum[W];
    gp_w.gen  = local_sum[W];
    gp_w.prop = &local_sum[W-1:0];
  end
endmodule

// File: rtl/hcsa_ks_prefix.sv
module hcsa_ks_prefix #(
  parameter int N = 8
) (
  input  hcsa_pkg::word_gp_t [N-1:0] gp_in,
  output logic [N:0]                 carry_into
);
  import hcsa_pkg::*;

  localparam int LVLS = (N > 1) ? $clog2(N) : 0;

  word_gp_t [N-1:0] lvl [0:LVLS];

  assign lvl[0] = gp_in;

  // Kogge-Stone: at level k every word merges with the word 2^k below.
  for (genvar k = 0; k < LVLS; k++) begin : g_lvl
    localparam int DIST = 1 << k;
    for (genvar i = 0; i < N; i++) begin : g_word
      if (i >= DIST) begin : g_merge
        assign lvl[k+1][i] = gp_merge(lvl[k][i], lvl[k][i-DIST]);
      end else begin : g_pass
        assign lvl[k+1][i] = lvl[k][i];
      end
    end
  end

  // Carry into word 0 is zero; the carry into word i+1 is the group generate of words 0..i.
  assign carry_into[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_out
    assign carry_into[i+1] = lvl[LVLS][i].gen;
  end
endmodule

// File: rtl/hcsa_word_inc.sv
module hcsa_word_inc #(
  parameter int W = 17
) (
  input  logic [W-1:0] s_w,
  input  logic         cin_w,
  output logic [W-1:0] r_w
);
  // The overflow of this increment is already accounted for by the prefix network.
  assign r_w = s_w + {{(W-1){1'b0}}, cin_w};
endmodule

// File: rtl/hcsa_adder_top.sv
module hcsa_adder_top #(
  parameter int N = 8,
  parameter int W = 17,
  localparam int NW = N * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] op_a,
  input  logic [NW-1:0] op_b,
  output logic [NW-1:0] cs_sum,
  output logic [NW:0]   cs_carry,
  output logic [NW-1:0] res_sum,
  output logic          res_cout
);
  import hcsa_pkg::*;

  logic [NW-1:0]     sum_d;
  logic [NW:0]       carry_d;
  logic [NW-1:0]     res_d;
  logic [N-1:0]      wcarry;
  word_gp_t [N-1:0]  gp;
  logic [N:0]        cin;

  for (genvar i = 0; i < N; i++) begin : g_words
    hcsa_word_add #(.W(W)) add_i (
      .a_w  (op_a[i*W +: W]),
      .b_w  (op_b[i*W +: W]),
      .s_w  (sum_d[i*W +: W]),
      .c_w  (wcarry[i]),
      .gp_w (gp[i])
    );

    // Carry-save carry vector: the word carry sits at the LSB of the next word.
    if (W > 1) begin : g_pad
      assign carry_d[i*W+1 +: W-1] = '0;
    end
    assign carry_d[(i+1)*W] = wcarry[i];

    hcsa_word_inc #(.W(W)) inc_i (
      .s_w   (sum_d[i*W +: W]),
      .cin_w (cin[i]),
      .r_w   (res_d[i*W +: W])
    );
  end
  assign carry_d[0] = 1'b0;

  hcsa_ks_prefix #(.N(N)) prefix_i (
    .gp_in      (gp),
    .carry_into (cin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_sum   <= '0;
      cs_carry <= '0;
      res_sum  <= '0;
      res_cout <= 1'b0;
    end else begin
      cs_sum   <= sum_d;
      cs_carry <= carry_d;
      res_sum  <= res_d;
      res_cout <= cin[N];
    end
  end
endmodule

// File: rtl/hcsa_adder_chk.sv
module hcsa_adder_chk #(
  parameter int N = 8,
  parameter int W = 17,
  localparam int NW = N * W
) (
  input logic          clk,
  input logic          rst,
  input logic [NW-1:0] op_a,
  input logic [NW-1:0] op_b,
  input logic [NW-1:0] cs_sum,
  input logic [NW:0]   cs_carry,
  input logic [NW-1:0] res_sum,
  input logic          res_cout
);
  logic          armed;
  logic [NW:0]   total_q;
  logic [NW-1:0] a_q;
  logic [NW-1:0] b_q;

  always_ff @(posedge clk) begin
    armed   <= !rst;
    total_q <= {1'b0, op_a} + {1'b0, op_b};
    a_q     <= op_a;
    b_q     <= op_b;
  end

  // R3: redundant pair sums to the resolved pair
  p_cs_equals_resolved_r3: assert property (@(posedge clk) disable iff (rst)
    armed |-> ({1'b0, cs_sum} + cs_carry) == {res_cout, res_sum});

  // R4 and R5: resolved pair matches operands sampled one edge earlier (R7)
  p_resolved_sum_r4: assert property (@(posedge clk) disable iff (rst)
    armed |-> res_sum == total_q[NW-1:0]);

  p_carry_out_r5: assert property (@(posedge clk) disable iff (rst)
    armed |-> res_cout == total_q[NW]);

  // R8: reset clears all outputs
  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (cs_sum == '0 && cs_carry == '0 && res_sum == '0 && !res_cout));

  // R1 and R2: per-word redundant form
  for (genvar i = 0; i < N; i++) begin : g_word_chk
    p_word_sum_r1: assert property (@(posedge clk) disable iff (rst)
      armed |-> ({cs_carry[(i+1)*W], cs_sum[i*W +: W]} ==
                 ({1'b0, a_q[i*W +: W]} + {1'b0, b_q[i*W +: W]})));
  end

  p_carry_lsb_zero_r2: assert property (@(posedge clk) disable iff (rst)
    armed |-> !cs_carry[0]);

  p_carry_sparse_r2: assert property (@(posedge clk) disable iff (rst)
    armed |-> $countones(cs_carry) <= N);
endmodule

bind hcsa_adder_top hcsa_adder_chk #(.N(N), .W(W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .op_a     (op_a),
  .op_b     (op_b),
  .cs_sum   (cs_sum),
  .cs_carry (cs_carry),
  .res_sum  (res_sum),
  .res_cout (res_cout)
);

// File: tb/hcsa_adder_top_tb_top.sv
module hcsa_adder_top_tb_top;
  localparam int N  = 8;
  localparam int W  = 17;
  localparam int NW = N * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NW-1:0] op_a = '0;
  logic [NW-1:0] op_b = '0;
  logic [NW-1:0] cs_sum;
  logic [NW:0]   cs_carry;
  logic [NW-1:0] res_sum;
  logic          res_cout;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  hcsa_adder_top #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
    .cs_sum(cs_sum), .cs_carry(cs_carry), .res_sum(res_sum), .res_cout(res_cout)
  );

  task automatic check_val(string req, logic [NW:0] act, logic [NW:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive on a falling edge, then sample on the next falling edge.
  task automatic apply_and_check(logic [NW-1:0] a, logic [NW-1:0] b);
    logic [NW:0]   tot;
    logic [NW-1:0] exp_s;
    logic [NW:0]   exp_c;
    logic [W:0]    wsum;
    @(negedge clk);
    op_a = a;
    op_b = b;
    tot   = {1'b0, a} + {1'b0, b};
    exp_c = '0;
    for (int i = 0; i < N; i++) begin
      wsum = {1'b0, a[i*W +: W]} + {1'b0, b[i*W +: W]};
      exp_s[i*W +: W] = wsum[W-1:0];
      exp_c[(i+1)*W]  = wsum[W];
    end
    @(negedge clk);
    check_val("R1", {1'b0, cs_sum}, {1'b0, exp_s});
    check_val("R2", cs_carry, exp_c);
    check_val("R3", {1'b0, cs_sum} + cs_carry, tot);
    check_val("R4", {1'b0, res_sum}, {1'b0, tot[NW-1:0]});
    check_val("R5", {{NW{1'b0}}, res_cout}, {{NW{1'b0}}, tot[NW]});
  endtask

  function automatic logic [NW-1:0] rand_word();
    logic [NW-1:0] v;
    for (int k = 0; k < NW; k++) v[k] = 1'($urandom() & 1);
    return v;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    rst  = 1'b1;
    op_a = '1;
    op_b = '1;
    @(negedge clk);
    // R8: outputs zero while reset held
    check_val("R8", {res_cout, res_sum}, '0);
    check_val("R8", cs_carry, '0);
    check_val("R8", {1'b0, cs_sum}, '0);
    rst = 1'b0;
  endtask

  task automatic t_random();
    for (int n = 0; n < 40; n++) apply_and_check(rand_word(), rand_word());
  endtask

  task automatic t_full_propagate();
    // R6: carry from word 0 through all-ones words to the carry-out
    apply_and_check('1, {{(NW-1){1'b0}}, 1'b1});
    check_val("R6", {res_cout, res_sum}, {1'b1, {NW{1'b0}}});
  endtask

  task automatic t_partial_propagate();
    logic [NW-1:0] a;
    logic [NW:0]   exp;
    // R6: words 0..3 all ones, carry must stop in word 4
    a = '0;
    a[4*W-1:0] = '1;
    exp = '0;
    exp[4*W] = 1'b1;
    apply_and_check(a, {{(NW-1){1'b0}}, 1'b1});
    check_val("R6", {res_cout, res_sum}, exp);
  endtask

  task automatic t_generated_then_propagated();
    logic [NW-1:0] a;
    logic [NW-1:0] b;
    // R6: word 2 generates, words 3..N-1 sum to all ones, carry reaches cout
    a = '0;
    b = '0;
    a[2*W +: W] = '1;
    b[2*W +: W] = {{(W-1){1'b0}}, 1'b1};
    for (int i = 3; i < N; i++) a[i*W +: W] = '1;
    apply_and_check(a, b);
    check_val("R6", {{NW{1'b0}}, res_cout}, {{NW{1'b0}}, 1'b1});
  endtask

  task automatic t_extremes();
    apply_and_check('1, '1);
    apply_and_check('0, '0);
  endtask

  task automatic t_latency();
    logic [NW-1:0] a1;
    logic [NW-1:0] b1;
    a1 = rand_word();
    b1 = rand_word();
    apply_and_check(a1, b1);
    // R7: new operands must not show before the next rising edge
    @(negedge clk);
    op_a = ~a1;
    op_b = b1;
    #1;
    check_val("R7", {res_cout, res_sum}, {1'b0, a1} + {1'b0, b1});
    @(negedge clk);
    check_val("R7", {res_cout, res_sum}, {1'b0, ~a1} + {1'b0, b1});
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_extremes();
    t_full_propagate();
    t_partial_propagate();
    t_generated_then_propagated();
    t_latency();
    t_random();
    t_reset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule